// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Receiver

This block is the serial slave front end of a register-mapped peripheral. A host selects it by pulling the active-low select low, then clocks in one 16-bit frame per access, most significant bit first. The first byte is a command address and the second is a data byte. When select returns high, the captured frame is held in a parallel latch and offered to the register bank behind the block as a one-cycle execute strobe carrying the address and data.

The serial output is always driven. In normal operation it repeats each input bit fifteen and a half serial clocks later, launched on the falling serial clock edge, so that several devices can be chained output-to-input and addressed with one long select window; address 0x00 is a no-operation that lets a chained device be skipped. When the address carries a read flag, the register bank returns a data byte in the strobe cycle, and the next frame shifts that byte out instead of the echo.

All three serial inputs are brought into the system clock domain through two-flop synchronisers, and the serial clock and select edges are found on the synchronised copies, so the system clock must run several times faster than the serial clock.

Top module: `spi_cmd_rx`

## Requirements
- R1: A data bit is captured on each rising serial clock edge seen while select is low, and bits enter the frame most significant first.
- R2: Serial clock and data activity while select is high has no effect: no strobe, no change of the serial output, and no change of the bits that a later frame echoes.
- R3: In the latched frame, bits 15:8 are the command address and bits 7:0 are the data byte.
- R4: A rise of select produces an execute strobe that is high for exactly one system clock cycle, with the latched address and data valid in that cycle.
- R5: In echo mode the serial output sampled at the k-th rising serial clock edge of a frame equals the k-th bit sent in the preceding frame (a 15.5-clock delay), and it changes only on falling serial clock edges inside a frame or when select rises.
- R6: A frame whose address is 0x00 raises no execute strobe.
- R7: A frame whose address has bit 7 set is a read query: the read data input is taken in its strobe cycle, and during the next frame the serial output presents that byte MSB first on rising edges 1 to 8 and 0 on edges 9 to 16; the frame after that echoes again.
- R8: If select rises after more or fewer than 16 captured bits, the last 16 bits captured form the frame.
- R9: A rising serial clock edge that reaches the block in the same system cycle as the rise of select is captured as the last bit of the frame.
- R10: After reset the serial output is 0 and the execute strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the serial host |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| rd_data | input | 8 | Read byte returned by the register bank during a query strobe |
| sdo | output | 1 | Serial data out, never high impedance |
| exec_valid | output | 1 | One-cycle execute strobe |
| exec_addr | output | 8 | Latched command address |
| exec_data | output | 8 | Latched data byte |

## Verification
The two functions that can fall in one system cycle are the capture of a bit on a rising serial clock edge and the latching of the frame on the rise of select. The bench provokes this by driving the sixteenth serial clock rise and the select rise at the same instant, so both pass through synchronisers of equal depth and are detected together. It judges the result by the address and data on the execute strobe, which must contain the coincident bit, and by the echo in the following frame, which must reproduce the whole 16-bit frame.

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              exec_valid,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [DATA_W-1:0] exec_data
);
  localparam int FW = ADDR_W + DATA_W;

  logic [SYNC_N:0]   cs_p, ck_p;
  logic [SYNC_N-1:0] di_p;
  logic [FW-1:0]     sreg, sreg_nx, rd_sh;
  logic              rd_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      ck_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[SYNC_N-1:0], cs_n};
      ck_p <= {ck_p[SYNC_N-1:0], sclk};
      di_p <= {di_p[SYNC_N-2:0], sdi};
    end
  end

  wire cs_s    = cs_p[SYNC_N-1];
  wire cs_d    = cs_p[SYNC_N];
  wire ck_s    = ck_p[SYNC_N-1];
  wire ck_d    = ck_p[SYNC_N];
  wire sdi_s   = di_p[SYNC_N-1];
  wire in_win  = ~cs_d;
  wire sh_en   = in_win & ck_s & ~ck_d;
  wire fall_en = in_win & ~ck_s & ck_d;
  wire cs_rise = cs_s & ~cs_d;
  wire query   = exec_valid & exec_addr[ADDR_W-1];

  assign sreg_nx = sh_en ? {sreg[FW-2:0], sdi_s} : sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '0;
    else        sreg <= sreg_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_valid <= 1'b0;
      exec_addr  <= '0;
      exec_data  <= '0;
    end else begin
      exec_valid <= cs_rise & (|sreg_nx[FW-1:DATA_W]);
      if (cs_rise) begin
        exec_addr <= sreg_nx[FW-1:DATA_W];
        exec_data <= sreg_nx[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo     <= 1'b0;
      rd_mode <= 1'b0;
      rd_sh   <= '0;
    end else if (query) begin
      sdo     <= rd_data[DATA_W-1];
      rd_sh   <= {rd_data[DATA_W-2:0], {(ADDR_W+1){1'b0}}};
      rd_mode <= 1'b1;
    end else if (cs_rise) begin
      sdo     <= sreg_nx[FW-1];
      rd_mode <= 1'b0;
    end else if (fall_en) begin
      if (rd_mode) begin
        sdo   <= rd_sh[FW-1];
        rd_sh <= {rd_sh[FW-2:0], 1'b0};
      end else begin
        sdo   <= sreg[FW-1];
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_d |=> $stable(sreg));
  assert_sdo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && cs_s && !exec_valid) |=> $stable(sdo));
  assert_strobe_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> $past(cs_s && !cs_d));
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |=> !exec_valid);
  assert_noop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (exec_addr != '0));
  assert_query_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_addr[ADDR_W-1]) |=> (rd_mode && sdo == $past(rd_data[DATA_W-1])));
endmodule

// File: tb/spi_cmd_rx_tb.sv
module spi_cmd_rx_tb;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [7:0] rd_data, exec_addr, exec_data;
  logic sdo, exec_valid;
  int checks = 0, failures = 0, ex_cnt = 0;
  logic [7:0] ex_a = 0, ex_d = 0;
  logic [15:0] obs = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign rd_data = exec_addr ^ 8'h5A;

  spi_cmd_rx u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .rd_data(rd_data), .sdo(sdo), .exec_valid(exec_valid),
    .exec_addr(exec_addr), .exec_data(exec_data));

  always @(negedge clk) if (rst_n && exec_valid) begin
    ex_cnt++; ex_a = exec_addr; ex_d = exec_data;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit together);
    cs_n = 0; wclk(5);
    for (int i = 0; i < n; i++) begin
      sdi = w[n-1-i]; wclk(3);
      obs = {obs[14:0], sdo};
      if (together && i == n-1) begin sclk = 1; cs_n = 1; end
      else sclk = 1;
      wclk(5); sclk = 0; wclk(5);
    end
    cs_n = 1; wclk(12);
  endtask

  task automatic t_reset;
    chk(sdo == 0, "R10 sdo after reset", sdo, 0);
    chk(exec_valid == 0, "R10 strobe after reset", exec_valid, 0);
  endtask

  task automatic t_basic;
    int c0 = ex_cnt;
    send(32'h1234, 16, 0);
    chk(ex_cnt == c0 + 1, "R4 one strobe cycle", ex_cnt - c0, 1);
    chk(ex_a == 8'h12, "R1 R3 address byte", ex_a, 8'h12);
    chk(ex_d == 8'h34, "R3 data byte", ex_d, 8'h34);
    chk(obs == 16'h0000, "R5 echo after reset", obs, 0);
    send(32'h2A5C, 16, 0);
    chk(ex_a == 8'h2A && ex_d == 8'h5C, "R1 second frame", {ex_a, ex_d}, 16'h2A5C);
    chk(obs == 16'h1234, "R5 echo of previous frame", obs, 16'h1234);
  endtask

  task automatic t_ignore;
    int c0 = ex_cnt;
    logic s0 = sdo;
    for (int i = 0; i < 10; i++) begin
      sdi = i[0]; wclk(3); sclk = 1; wclk(5); sclk = 0; wclk(5);
    end
    wclk(10);
    chk(sdo == s0, "R2 sdo unchanged when deselected", sdo, s0);
    chk(ex_cnt == c0, "R2 no strobe when deselected", ex_cnt, c0);
    send(32'h00FF, 16, 0);
    chk(ex_cnt == c0, "R6 no-op raises no strobe", ex_cnt, c0);
    chk(obs == 16'h2A5C, "R2 echo kept across idle activity", obs, 16'h2A5C);
  endtask

  task automatic t_read;
    int c0 = ex_cnt;
    send(32'h8300, 16, 0);
    chk(ex_cnt == c0 + 1 && ex_a == 8'h83, "R7 query strobe", ex_a, 8'h83);
    send(32'h4411, 16, 0);
    chk(obs == 16'hD900, "R7 read byte on sdo", obs, 16'hD900);
    chk(ex_a == 8'h44 && ex_d == 8'h11, "R3 frame during read-out", {ex_a, ex_d}, 16'h4411);
    send(32'h0000, 16, 0);
    chk(obs == 16'h4411, "R7 echo resumes", obs, 16'h4411);
  endtask

  task automatic t_odd;
    int c0 = ex_cnt;
    send(32'hA5566, 20, 0);
    chk(ex_cnt == c0 + 1, "R8 strobe after 20 bits", ex_cnt - c0, 1);
    chk({ex_a, ex_d} == 16'h5566, "R8 last 16 bits kept", {ex_a, ex_d}, 16'h5566);
  endtask

  task automatic t_coincide;
    send(32'h7E81, 16, 1);
    chk({ex_a, ex_d} == 16'h7E81, "R9 coincident last bit latched", {ex_a, ex_d}, 16'h7E81);
    send(32'h0000, 16, 0);
    chk(obs == 16'h7E81, "R9 R5 echo of coincident frame", obs, 16'h7E81);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wclk(4); rst_n = 1; wclk(4);
    t_reset();
    t_basic();
    t_ignore();
    t_read();
    t_odd();
    t_coincide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule